// File: doc/BRIEF.md
# Dispatch Group Former

This block takes an in-order stream of decoded instructions and packs them into dispatch groups of six slots. Slots 1 to 4 take non-branch operations and slots 5 and 6 take branches. Each instruction carries a 3-bit class code that states which slots it needs. The block fills the group being built one instruction per cycle. It seals that group when the next instruction cannot be placed, when a second branch has been placed, or when the input goes idle. A sealed group moves into a registered output stage. That stage presents a per-slot valid mask and the tag of the instruction in each slot.

Both edges are valid/ready streams. An input instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops only when two things hold together: the offered instruction needs a fresh group, and the output stage holds a group that is not being drained in that cycle. A group on the output stays in place, unchanged, until `grp_ready` is high. The `flush` pin is plain control. It empties the group being built and the output stage in one cycle.

Top module: `dispatch_grouper`

## Requirements
- R1: An instruction is accepted on a rising edge with `in_valid` and `in_ready` high. `in_ready` is low while `flush` is high. It is also low when the offered instruction must start a new group while the output holds a group and `grp_ready` is low. In every other case it is high.
- R2: Mask bit i stands for slot i+1. Bits 0 to 3 are the non-branch slots and bits 4 and 5 are the branch slots. Non-branch slots fill contiguously from slot 1 in program order, and branches fill slot 5 first, then slot 6.
- R3: Class 0 (plain), and the reserved codes 6 and 7, take the next free non-branch slot. This is possible only while fewer than four non-branch slots are used.
- R4: Class 1 (first-slot-only) can be placed only in slot 1. It therefore joins a group only when no non-branch slot is used yet.
- R5: Class 2 (cracked pair) needs an empty non-branch side. It occupies slots 1 and 2, and both slots carry its tag.
- R6: Class 3 (all-four) needs an empty non-branch side. It occupies slots 1 to 4, all four carrying its tag.
- R7: Class 4 (permute) can be placed only in slot 1 or slot 2. It fits only while fewer than two non-branch slots are used.
- R8: Class 5 (branch) takes a branch slot. A first branch leaves the group open. Once a second branch is placed, the group seals, and the next instruction starts a new group.
- R9: An instruction that does not fit seals the current group. It is accepted in the same cycle as the first member of the next group. Instructions are never reordered.
- R10: A cycle with `in_valid` low seals a non-empty group, provided the output stage is free in that cycle.
- R11: The output group appears one cycle after sealing. It holds mask and tags stable while `grp_valid` is high and `grp_ready` is low, and the tag field of every unused slot reads zero.
- R12: `flush` clears `grp_valid` on the next edge and discards the group being built, so no flushed instruction is ever emitted.
- R13: While and right after reset, `grp_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Discard built and held groups |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken |
| in_class | input | 3 | Slot class code |
| in_tag | input | TAG_W | Instruction tag carried to its slots |
| grp_valid | output | 1 | A sealed group is presented |
| grp_ready | input | 1 | Consumer takes the group |
| grp_mask | output | NB_SLOTS+BR_SLOTS | Per-slot occupancy |
| grp_tags | output | (NB_SLOTS+BR_SLOTS)*TAG_W | Slot tags, slot i at bits i*TAG_W |

## Verification
Some properties are checked on every cycle. The output mask must keep its shape: non-branch bits contiguous from slot 1, branch bits contiguous from slot 5, and never empty. Unused slot tags must read zero. A stalled group must stay stable, a flush must empty the output, and input must be refused during a flush. Other behaviour shows up only in the bench's instruction sequences. These are which instruction seals a group, that tags keep program order across groups, that an idle cycle seals a group, and that back-pressure parks a non-fitting instruction. They are compared against a transaction-level grouping model.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam logic [2:0] CLS_ANY   = 3'd0;
  localparam logic [2:0] CLS_FIRST = 3'd1;
  localparam logic [2:0] CLS_PAIR  = 3'd2;
  localparam logic [2:0] CLS_QUAD  = 3'd3;
  localparam logic [2:0] CLS_PERM  = 3'd4;
  localparam logic [2:0] CLS_BR    = 3'd5;
endpackage

// File: rtl/dgf_slot_fit.sv
module dgf_slot_fit import dgf_pkg::*; #(
  parameter int NB_SLOTS = 4,
  parameter int BR_SLOTS = 2,
  localparam int NSLOT = NB_SLOTS + BR_SLOTS,
  localparam int NB_CW = $clog2(NB_SLOTS + 1),
  localparam int BR_CW = $clog2(BR_SLOTS + 1)
) (
  input  logic [NB_CW-1:0] nb_cnt,
  input  logic [BR_CW-1:0] br_cnt,
  input  logic [2:0]       cls,
  output logic             fits,
  output logic [NB_CW-1:0] nxt_nb,
  output logic [BR_CW-1:0] nxt_br,
  output logic [NSLOT-1:0] place
);
  always_comb begin
    fits   = 1'b0;
    nxt_nb = nb_cnt;
    nxt_br = br_cnt;
    place  = '0;
    case (cls)
      CLS_BR: if (br_cnt < BR_CW'(BR_SLOTS)) begin
        fits   = 1'b1;
        nxt_br = br_cnt + BR_CW'(1);
        for (int i = 0; i < BR_SLOTS; i++)
          if (i == int'(br_cnt)) place[NB_SLOTS+i] = 1'b1;
      end
      CLS_FIRST: if (nb_cnt == '0) begin
        fits     = 1'b1;
        nxt_nb   = NB_CW'(1);
        place[0] = 1'b1;
      end
      CLS_PAIR: if (nb_cnt == '0) begin
        fits     = 1'b1;
        nxt_nb   = NB_CW'(2);
        place[0] = 1'b1;
        place[1] = 1'b1;
      end
      CLS_QUAD: if (nb_cnt == '0) begin
        fits   = 1'b1;
        nxt_nb = NB_CW'(NB_SLOTS);
        for (int i = 0; i < NB_SLOTS; i++) place[i] = 1'b1;
      end
      CLS_PERM: if (nb_cnt < NB_CW'(2)) begin
        fits   = 1'b1;
        nxt_nb = nb_cnt + NB_CW'(1);
        for (int i = 0; i < 2; i++)
          if (i == int'(nb_cnt)) place[i] = 1'b1;
      end
      default: if (nb_cnt < NB_CW'(NB_SLOTS)) begin
        fits   = 1'b1;
        nxt_nb = nb_cnt + NB_CW'(1);
        for (int i = 0; i < NB_SLOTS; i++)
          if (i == int'(nb_cnt)) place[i] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/dgf_slot_store.sv
module dgf_slot_store #(
  parameter int NSLOT = 6,
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [NSLOT-1:0]       wmask,
  input  logic [TAG_W-1:0]       tag,
  output logic [NSLOT*TAG_W-1:0] tags
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                 tags[g*TAG_W +: TAG_W] <= '0;
      else if (we && wmask[g]) tags[g*TAG_W +: TAG_W] <= tag;
    end
  end
endmodule

// File: rtl/dgf_group_reg.sv
module dgf_group_reg #(
  parameter int NSLOT = 6,
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   load,
  input  logic [NSLOT-1:0]       mask_in,
  input  logic [NSLOT*TAG_W-1:0] tags_in,
  input  logic                   ready,
  output logic                   valid,
  output logic [NSLOT-1:0]       mask,
  output logic [NSLOT*TAG_W-1:0] tags,
  output logic                   free
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid <= 1'b0;
      mask  <= '0;
      tags  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      mask  <= mask_in;
      tags  <= tags_in;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dispatch_grouper.sv
module dispatch_grouper #(
  parameter int NB_SLOTS = 4,
  parameter int BR_SLOTS = 2,
  parameter int TAG_W    = 8,
  localparam int NSLOT   = NB_SLOTS + BR_SLOTS,
  localparam int NB_CW   = $clog2(NB_SLOTS + 1),
  localparam int BR_CW   = $clog2(BR_SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [2:0]             in_class,
  input  logic [TAG_W-1:0]       in_tag,
  output logic                   grp_valid,
  input  logic                   grp_ready,
  output logic [NSLOT-1:0]       grp_mask,
  output logic [NSLOT*TAG_W-1:0] grp_tags
);
  logic [NB_CW-1:0] nb_cnt, cur_nb, new_nb;
  logic [BR_CW-1:0] br_cnt, cur_br, new_br;
  logic             cur_fits, new_fits;
  logic [NSLOT-1:0] cur_place, new_place, bmask;
  logic [NSLOT*TAG_W-1:0] btags, masked_tags;
  logic occupied, br_full, need_new, out_free, accept, seal;

  // placement against the group being built
  dgf_slot_fit #(.NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS)) u_fit_cur (
    .nb_cnt(nb_cnt), .br_cnt(br_cnt), .cls(in_class),
    .fits(cur_fits), .nxt_nb(cur_nb), .nxt_br(cur_br), .place(cur_place));

  // placement into an empty group
  dgf_slot_fit #(.NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS)) u_fit_new (
    .nb_cnt('0), .br_cnt('0), .cls(in_class),
    .fits(new_fits), .nxt_nb(new_nb), .nxt_br(new_br), .place(new_place));

  assign occupied = (nb_cnt != '0) || (br_cnt != '0);
  assign br_full  = (br_cnt == BR_CW'(BR_SLOTS));
  assign need_new = occupied && (br_full || !cur_fits);
  assign in_ready = !flush && (!need_new || out_free);
  assign accept   = in_valid && in_ready;
  assign seal     = !flush && occupied && out_free &&
                    (br_full || !in_valid || !cur_fits);

  for (genvar g = 0; g < NSLOT; g++) begin : g_mask
    if (g < NB_SLOTS) begin : g_nb
      assign bmask[g] = (g < int'(nb_cnt));
    end else begin : g_br
      assign bmask[g] = ((g - NB_SLOTS) < int'(br_cnt));
    end
    assign masked_tags[g*TAG_W +: TAG_W] = bmask[g] ? btags[g*TAG_W +: TAG_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      nb_cnt <= '0;
      br_cnt <= '0;
    end else if (seal) begin
      nb_cnt <= accept ? new_nb : '0;
      br_cnt <= accept ? new_br : '0;
    end else if (accept) begin
      nb_cnt <= cur_nb;
      br_cnt <= cur_br;
    end
  end

  dgf_slot_store #(.NSLOT(NSLOT), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst), .we(accept),
    .wmask(seal ? new_place : cur_place), .tag(in_tag), .tags(btags));

  dgf_group_reg #(.NSLOT(NSLOT), .TAG_W(TAG_W)) u_out (
    .clk(clk), .rst(rst), .flush(flush), .load(seal),
    .mask_in(bmask), .tags_in(masked_tags), .ready(grp_ready),
    .valid(grp_valid), .mask(grp_mask), .tags(grp_tags), .free(out_free));

  logic unused_fit;
  assign unused_fit = new_fits;
endmodule

// File: rtl/dispatch_grouper_chk.sv
module dispatch_grouper_chk #(
  parameter int NB_SLOTS = 4,
  parameter int BR_SLOTS = 2,
  parameter int TAG_W    = 8,
  localparam int NSLOT   = NB_SLOTS + BR_SLOTS
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   flush,
  input logic                   in_ready,
  input logic                   grp_valid,
  input logic                   grp_ready,
  input logic [NSLOT-1:0]       grp_mask,
  input logic [NSLOT*TAG_W-1:0] grp_tags
);
  logic [NB_SLOTS-1:0] nbm;
  logic [BR_SLOTS-1:0] brm;
  logic                tags_clean;
  assign nbm = grp_mask[NB_SLOTS-1:0];
  assign brm = grp_mask[NSLOT-1:NB_SLOTS];

  always_comb begin
    tags_clean = 1'b1;
    for (int i = 0; i < NSLOT; i++)
      if (!grp_mask[i] && grp_tags[i*TAG_W +: TAG_W] != '0) tags_clean = 1'b0;
  end

  // R2: slot fill shape
  p_mask_shape_r2: assert property (@(posedge clk) disable iff (rst)
    grp_valid |-> ((nbm & (nbm + 1'b1)) == '0) && ((brm & (brm + 1'b1)) == '0)
                  && (grp_mask != '0));

  // R11: unused slots carry zero
  p_unused_zero_r11: assert property (@(posedge clk) disable iff (rst)
    grp_valid |-> tags_clean);

  // R11: stalled group held
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && !grp_ready && !flush) |=>
      (grp_valid && $stable(grp_mask) && $stable(grp_tags)));

  // R12: flush empties output
  p_flush_r12: assert property (@(posedge clk) disable iff (rst)
    flush |=> !grp_valid);

  // R1: nothing taken during flush
  p_flush_block_r1: assert property (@(posedge clk) disable iff (rst)
    flush |-> !in_ready);
endmodule

bind dispatch_grouper dispatch_grouper_chk #(
  .NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .in_ready(in_ready),
  .grp_valid(grp_valid), .grp_ready(grp_ready),
  .grp_mask(grp_mask), .grp_tags(grp_tags));

// File: tb/dispatch_grouper_test.sv
module dispatch_grouper_test;
  localparam int TW = 8;
  localparam int NS = 6;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic in_valid = 1'b0, in_ready, grp_valid, grp_ready = 1'b0;
  logic [2:0] in_class = '0;
  logic [TW-1:0] in_tag = '0;
  logic [NS-1:0] grp_mask;
  logic [NS*TW-1:0] grp_tags;

  int checks = 0, errors = 0, cycles = 0;
  int rmode = 1;  // 0 stall, 1 always ready, 2 random

  always #2 clk = ~clk;

  dispatch_grouper #(.NB_SLOTS(4), .BR_SLOTS(2), .TAG_W(TW)) uut (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_class(in_class), .in_tag(in_tag),
    .grp_valid(grp_valid), .grp_ready(grp_ready),
    .grp_mask(grp_mask), .grp_tags(grp_tags));

  // expected groups
  logic [NS-1:0]    q_mask[$];
  logic [NS*TW-1:0] q_tags[$];
  string            q_req[$];
  int m_nb = 0, m_br = 0;
  logic [NS-1:0]    m_mask = '0;
  logic [NS*TW-1:0] m_tags = '0;
  string            m_req = "R9";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic m_close();
    if (m_mask != '0) begin
      q_mask.push_back(m_mask);
      q_tags.push_back(m_tags);
      q_req.push_back(m_req);
    end
    m_nb = 0; m_br = 0; m_mask = '0; m_tags = '0;
  endtask

  task automatic m_put(input int s, input logic [TW-1:0] t);
    m_mask[s] = 1'b1;
    m_tags[s*TW +: TW] = t;
  endtask

  task automatic m_add(input logic [2:0] c, input logic [TW-1:0] t);
    bit ok;
    if (m_br == 2) begin m_req = "R8"; m_close(); end
    case (c)
      3'd5: ok = (m_br < 2);
      3'd1, 3'd2, 3'd3: ok = (m_nb == 0);
      3'd4: ok = (m_nb < 2);
      default: ok = (m_nb < 4);
    endcase
    if (!ok) begin m_req = "R9"; m_close(); end
    case (c)
      3'd5: begin m_put(4 + m_br, t); m_br++; end
      3'd2: begin m_put(0, t); m_put(1, t); m_nb = 2; end
      3'd3: begin for (int i = 0; i < 4; i++) m_put(i, t); m_nb = 4; end
      default: begin m_put(m_nb, t); m_nb++; end
    endcase
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && grp_valid && grp_ready) begin
      if (q_mask.size() == 0) begin
        check(0, "R9", "unexpected group mask", 64'(grp_mask), 0);
      end else begin
        check(grp_mask == q_mask[0], q_req[0], "group mask",
              64'(grp_mask), 64'(q_mask[0]));
        check(grp_tags == q_tags[0], "R2", "group tags",
              64'(grp_tags), 64'(q_tags[0]));
        void'(q_mask.pop_front()); void'(q_tags.pop_front());
        void'(q_req.pop_front());
      end
    end
  end

  // output back-pressure
  initial begin
    forever begin
      @(posedge clk); #1;
      grp_ready = (rmode == 1) || (rmode == 2 && ($urandom % 10) < 7);
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  logic [2:0]    b_cls[32];
  logic [TW-1:0] b_tag[32];
  int            b_n;

  task automatic drive_burst();
    for (int i = 0; i < b_n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_class = b_cls[i]; in_tag = b_tag[i];
      @(negedge clk);
      while (!in_ready) @(negedge clk);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic model_burst();
    m_req = "R9";
    for (int i = 0; i < b_n; i++) m_add(b_cls[i], b_tag[i]);
    m_req = "R10";
    m_close();
  endtask

  task automatic drain();
    int w = 0;
    while (q_mask.size() != 0 && w < 2000) begin @(negedge clk); w++; end
    check(q_mask.size() == 0, "R10", "groups left undelivered", 64'(q_mask.size()), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input logic [2:0] c[], input logic [TW-1:0] t0);
    b_n = c.size();
    for (int i = 0; i < b_n; i++) begin b_cls[i] = c[i]; b_tag[i] = t0 + TW'(i); end
    model_burst();
    drive_burst();
    drain();
  endtask

  initial begin
    logic [NS-1:0] held;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(grp_valid == 1'b0, "R13", "valid in reset", 64'(grp_valid), 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(grp_valid == 1'b0, "R13", "valid after reset", 64'(grp_valid), 0);
    check(in_ready == 1'b1, "R13", "ready after reset", 64'(in_ready), 1);

    // R8: branch keeps group open, second branch seals
    run('{3'd0, 3'd5, 3'd0, 3'd5, 3'd0}, 8'h10);
    // R4 first-only after a branch, then blocked
    run('{3'd5, 3'd1, 3'd0, 3'd1}, 8'h20);
    // R5 pair, R6 quad, R7 permute
    run('{3'd2, 3'd0, 3'd0, 3'd2, 3'd3, 3'd5, 3'd0}, 8'h30);
    run('{3'd4, 3'd4, 3'd4, 3'd0, 3'd4}, 8'h40);
    // R3 reserved codes behave as plain, five plain overflow
    run('{3'd6, 3'd7, 3'd0, 3'd0, 3'd0}, 8'h50);

    // R1/R11: stalled output parks a non-fitting instruction
    rmode = 0;
    b_n = 5;
    b_cls[0] = 3'd5; b_cls[1] = 3'd5; b_cls[2] = 3'd0; b_cls[3] = 3'd0; b_cls[4] = 3'd3;
    for (int i = 0; i < 5; i++) b_tag[i] = 8'h60 + 8'(i);
    model_burst();
    fork
      drive_burst();
      begin
        @(negedge clk);
        while (!(in_valid && in_class == 3'd3)) @(negedge clk);
        repeat (2) @(negedge clk);
        check(in_ready == 1'b0, "R1", "ready with full output", 64'(in_ready), 0);
        check(grp_valid == 1'b1, "R11", "held group valid", 64'(grp_valid), 1);
        held = grp_mask;
        repeat (3) @(negedge clk);
        check(grp_mask == held, "R11", "held mask stable", 64'(grp_mask), 64'(held));
        rmode = 1;
      end
    join
    drain();

    // R12: flush discards building and held groups
    rmode = 0;
    b_n = 6;
    b_cls[0] = 3'd0; b_cls[1] = 3'd5; b_cls[2] = 3'd5;
    b_cls[3] = 3'd0; b_cls[4] = 3'd0; b_cls[5] = 3'd5;
    for (int i = 0; i < 6; i++) b_tag[i] = 8'h70 + 8'(i);
    drive_burst();
    @(negedge clk);
    check(grp_valid == 1'b1, "R12", "group held before flush", 64'(grp_valid), 1);
    @(posedge clk); #1 flush = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R1", "ready during flush", 64'(in_ready), 0);
    @(posedge clk); #1 flush = 1'b0;
    @(negedge clk);
    check(grp_valid == 1'b0, "R12", "valid after flush", 64'(grp_valid), 0);
    rmode = 1;
    repeat (3) @(negedge clk);
    check(grp_valid == 1'b0, "R12", "no flushed group emitted", 64'(grp_valid), 0);
    run('{3'd0}, 8'h7F);

    // constrained random bursts
    rmode = 2;
    for (int k = 0; k < 60; k++) begin
      b_n = 1 + int'($urandom % 12);
      for (int i = 0; i < b_n; i++) begin
        int r = int'($urandom % 16);
        b_cls[i] = (r < 6) ? 3'd0 : (r < 8) ? 3'd5 : (r < 9) ? 3'd1 :
                   (r < 11) ? 3'd2 : (r < 12) ? 3'd3 : (r < 14) ? 3'd4 :
                   3'(6 + (r & 1));
        b_tag[i] = 8'($urandom % 255) + 8'd1;
      end
      model_burst();
      drive_burst();
      drain();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule